// File: doc/BRIEF.md
# Dual-Scan Passive LCD Timing Generator

This block produces every timing signal a monochrome dual-scan passive-matrix panel needs. The panel is split into an upper and a lower half that are scanned at the same time, so each shift-clock pulse carries four pixels for each half on two separate 4-bit data buses. The shift clock does not run continuously. It comes in one fixed-length burst per line, a single line-latch pulse follows each burst, and the output then stays idle until the next line period begins. The first-line marker frames each field. The AC-drive output is simply held high, because the panel alternates its drive on its own.

The length of a burst never changes, and neither does the shift-clock period, which is a fixed number of reference-clock cycles. The colour depth selects only the line period. A 1-bit depth gives the longest line, a 4-bit depth the shortest, and the idle time after the latch pulse takes up the difference. A new depth takes effect only at the next frame boundary, so a field never mixes two line periods.

Pixel bytes come in through a valid/ready stream. One beat is taken for each shift-clock pulse: the high nibble goes to the upper half and the low nibble to the lower half. The panel cannot be stalled, so the block never waits for the source. `pix_ready` is high for exactly one clock before each burst slot. If no beat is offered in that clock, the slot is sent blank. A source that raises `pix_valid` must hold it, with its data unchanged, until it sees `pix_ready`.

Top module: `lcd_dualscan_timing`

## Requirements
- R1: While `rst` is high, all outputs, `pix_ready` included, are low.
- R2: Every line has exactly `PIX_PER_LINE` shift-clock pulses in one unbroken burst. Each pulse lasts `2*CL2_HALF` clocks and is high for the first `CL2_HALF` of them, in every mode.
- R3: The slot right after the burst carries one line-latch pulse, one shift-clock period wide. The shift clock is never high while the latch pulse is high, and nothing toggles for the rest of the line period.
- R4: The line period, counted in shift-clock periods, is `LINE_CL2_D1` when `mode_sel` is 2'b00, `LINE_CL2_D2` when it is 2'b01, and `LINE_CL2_D4` when it is 2'b10 or 2'b11.
- R5: A frame has `FRAME_LINES` line periods. The first-line marker rises at shift-clock slot `FLM_DELAY` of line 0 and falls when that line's latch pulse ends.
- R6: `mode_sel` is sampled during reset and at the end of the last line of each frame, and nowhere else. A change in the middle of a frame leaves that frame's line period unchanged.
- R7: `lcd_du` carries bits [7:4] of the accepted byte and `lcd_dl` carries bits [3:0]. Both change only when the shift clock rises and stay stable through its falling edge.
- R8: `pix_ready` is high for one clock: the last clock before each burst slot, and once more in the first clock after reset is released. A beat is accepted when `pix_valid` and `pix_ready` are both high.
- R9: A burst slot whose ready clock had no valid beat sends 4'h0 on both nibbles. Both nibbles are 4'h0 outside bursts.
- R10: `lcd_m` is low during reset and high from the first active clock on.
- R11: After reset is released, the first shift-clock pulse starts on the second clock edge, at line 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Colour depth: 00 = 1-bit, 01 = 2-bit, 10/11 = 4-bit |
| pix_valid | input | 1 | Source holds a pixel beat |
| pix_ready | output | 1 | Block takes a beat in this clock |
| pix_data | input | 8 | [7:4] upper-half pixels, [3:0] lower-half pixels |
| lcd_cl2 | output | 1 | Burst shift clock; the panel latches on its falling edge |
| lcd_cl1 | output | 1 | Line-latch pulse |
| lcd_flm | output | 1 | First-line marker |
| lcd_m | output | 1 | AC-drive level, held high |
| lcd_du | output | 4 | Upper-half data nibble |
| lcd_dl | output | 4 | Lower-half data nibble |

## Verification
The checker assumes the parameters give a line period at least two slots longer than the burst and a marker delay shorter than the burst. Under those conditions the latch slot and the idle time always exist. It also assumes the source keeps `pix_valid` and `pix_data` steady from one ready clock to the next. The bench changes its beat only just after an accepted ready clock, and it drops `pix_valid` only in a gap pattern. This exercises blank slots without breaking the hold rule. Mode changes and the reset release are driven just after a rising edge, so the sampling clock of R6 always sees one settled value.

// File: rtl/lcd_dualscan_pkg.sv
package lcd_dualscan_pkg;
  // Colour-depth selector; both 4-bit codes map to the shortest line.
  typedef enum logic [1:0] {
    DEPTH_1  = 2'b00,
    DEPTH_2  = 2'b01,
    DEPTH_4  = 2'b10,
    DEPTH_4X = 2'b11
  } depth_e;
endpackage

// File: rtl/lcd_cl2_phase.sv
// Divides the reference clock into shift-clock slots.
module lcd_cl2_phase #(
  parameter int unsigned CL2_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic phase_last,
  output logic hi_half
);
  localparam int unsigned PER = 2 * CL2_HALF;
  localparam int unsigned PW  = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PER - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(CL2_HALF);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)      ph <= '0;
    else if (run) ph <= phase_last ? '0 : ph + 1'b1;
  end

  assign phase_last = (ph == PH_LAST);
  assign hi_half    = (ph < PH_HALF);
endmodule

// File: rtl/lcd_scan_ctr.sv
// Slot and line position plus frame-aligned depth latch.
module lcd_scan_ctr
  import lcd_dualscan_pkg::*;
#(
  parameter int unsigned PIX_PER_LINE = 160,
  parameter int unsigned FRAME_LINES  = 200,
  parameter int unsigned FLM_DELAY    = 3,
  parameter int unsigned LINE_CL2_D1  = 313,
  parameter int unsigned LINE_CL2_D2  = 219,
  parameter int unsigned LINE_CL2_D4  = 164
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   step,
  input  depth_e mode_sel,
  output logic   in_burst,
  output logic   is_latch,
  output logic   next_in_burst,
  output logic   flm_win
);
  localparam int unsigned LP_A   = (LINE_CL2_D1 > LINE_CL2_D2) ? LINE_CL2_D1 : LINE_CL2_D2;
  localparam int unsigned LP_MAX = (LP_A > LINE_CL2_D4) ? LP_A : LINE_CL2_D4;
  localparam int unsigned SW     = $clog2(LP_MAX + 1);
  localparam int unsigned LW     = $clog2(FRAME_LINES + 1);
  localparam logic [SW-1:0] PIX_S  = SW'(PIX_PER_LINE);
  localparam logic [SW-1:0] DLY_S  = SW'(FLM_DELAY);
  localparam logic [SW-1:0] LP1_S  = SW'(LINE_CL2_D1);
  localparam logic [SW-1:0] LP2_S  = SW'(LINE_CL2_D2);
  localparam logic [SW-1:0] LP4_S  = SW'(LINE_CL2_D4);
  localparam logic [LW-1:0] LAST_L = LW'(FRAME_LINES - 1);

  depth_e        mode_q;
  logic [SW-1:0] slot;
  logic [SW-1:0] lp;
  logic [LW-1:0] line;
  logic          slot_end;
  logic          frame_end;

  always_comb begin
    case (mode_q)
      DEPTH_1: lp = LP1_S;
      DEPTH_2: lp = LP2_S;
      default: lp = LP4_S;
    endcase
  end

  assign slot_end  = (slot == lp - 1'b1);
  assign frame_end = slot_end && (line == LAST_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      line   <= '0;
      mode_q <= mode_sel;
    end else if (run && step) begin
      if (slot_end) begin
        slot <= '0;
        line <= (line == LAST_L) ? '0 : line + 1'b1;
        if (frame_end) mode_q <= mode_sel;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign in_burst      = (slot < PIX_S);
  assign is_latch      = (slot == PIX_S);
  assign next_in_burst = slot_end || ((slot + 1'b1) < PIX_S);
  assign flm_win       = (line == '0) && (slot >= DLY_S) && (slot <= PIX_S);
endmodule

// File: rtl/lcd_pix_fetch.sv
// Takes one pixel beat per burst slot and drives both nibble buses.
module lcd_pix_fetch (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       phase_last,
  input  logic       next_in_burst,
  input  logic       pix_valid,
  input  logic [7:0] pix_data,
  output logic       pix_ready,
  output logic [3:0] upper,
  output logic [3:0] lower
);
  logic [7:0] beat_q;

  assign pix_ready = !rst && (!run || (phase_last && next_in_burst));

  always_ff @(posedge clk) begin
    if (rst)                    beat_q <= '0;
    else if (pix_ready)         beat_q <= pix_valid ? pix_data : 8'h00;
    else if (run && phase_last) beat_q <= '0;
  end

  assign upper = beat_q[7:4];
  assign lower = beat_q[3:0];
endmodule

// File: rtl/lcd_dualscan_timing.sv
module lcd_dualscan_timing
  import lcd_dualscan_pkg::*;
#(
  parameter int unsigned CL2_HALF     = 2,
  parameter int unsigned PIX_PER_LINE = 160,
  parameter int unsigned FRAME_LINES  = 200,
  parameter int unsigned FLM_DELAY    = 3,
  parameter int unsigned LINE_CL2_D1  = 313,
  parameter int unsigned LINE_CL2_D2  = 219,
  parameter int unsigned LINE_CL2_D4  = 164
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       pix_valid,
  output logic       pix_ready,
  input  logic [7:0] pix_data,
  output logic       lcd_cl2,
  output logic       lcd_cl1,
  output logic       lcd_flm,
  output logic       lcd_m,
  output logic [3:0] lcd_du,
  output logic [3:0] lcd_dl
);
  if (LINE_CL2_D1 < PIX_PER_LINE + 2 || LINE_CL2_D2 < PIX_PER_LINE + 2 ||
      LINE_CL2_D4 < PIX_PER_LINE + 2 || FLM_DELAY >= PIX_PER_LINE ||
      CL2_HALF < 1 || FRAME_LINES < 2) begin : g_bad_cfg
    $error("lcd_dualscan_timing: inconsistent timing parameters");
  end

  logic run_q;
  logic phase_last, hi_half;
  logic in_burst, is_latch, next_in_burst, flm_win;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  lcd_cl2_phase #(.CL2_HALF(CL2_HALF)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .phase_last (phase_last),
    .hi_half    (hi_half)
  );

  lcd_scan_ctr #(
    .PIX_PER_LINE (PIX_PER_LINE),
    .FRAME_LINES  (FRAME_LINES),
    .FLM_DELAY    (FLM_DELAY),
    .LINE_CL2_D1  (LINE_CL2_D1),
    .LINE_CL2_D2  (LINE_CL2_D2),
    .LINE_CL2_D4  (LINE_CL2_D4)
  ) u_scan (
    .clk           (clk),
    .rst           (rst),
    .run           (run_q),
    .step          (phase_last),
    .mode_sel      (depth_e'(mode_sel)),
    .in_burst      (in_burst),
    .is_latch      (is_latch),
    .next_in_burst (next_in_burst),
    .flm_win       (flm_win)
  );

  lcd_pix_fetch u_fetch (
    .clk           (clk),
    .rst           (rst),
    .run           (run_q),
    .phase_last    (phase_last),
    .next_in_burst (next_in_burst),
    .pix_valid     (pix_valid),
    .pix_data      (pix_data),
    .pix_ready     (pix_ready),
    .upper         (lcd_du),
    .lower         (lcd_dl)
  );

  assign lcd_cl2 = run_q && in_burst && hi_half;
  assign lcd_cl1 = run_q && is_latch;
  assign lcd_flm = run_q && flm_win;
  assign lcd_m   = run_q;
endmodule

// File: rtl/lcd_dualscan_timing_chk.sv
module lcd_dualscan_timing_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_ready,
  input logic       lcd_cl2,
  input logic       lcd_cl1,
  input logic       lcd_flm,
  input logic       lcd_m,
  input logic [3:0] lcd_du,
  input logic [3:0] lcd_dl
);
  // R3
  cl_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(lcd_cl1 && lcd_cl2));

  // R5
  flm_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_flm) |-> $fell(lcd_cl1));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_cl2) |-> $stable({lcd_du, lcd_dl}));

  // R8
  ready_lead_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> lcd_cl2);

  // R9
  latch_blank_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_cl1 |-> ({lcd_du, lcd_dl} == 8'h00));

  // R10
  m_high_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_cl2 || lcd_cl1 || lcd_flm) |-> lcd_m);
endmodule

bind lcd_dualscan_timing lcd_dualscan_timing_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_ready (pix_ready),
  .lcd_cl2   (lcd_cl2),
  .lcd_cl1   (lcd_cl1),
  .lcd_flm   (lcd_flm),
  .lcd_m     (lcd_m),
  .lcd_du    (lcd_du),
  .lcd_dl    (lcd_dl)
);

// File: tb/lcd_dualscan_timing_tb.sv
module lcd_dualscan_timing_tb;
  localparam int HALF = 2;
  localparam int PIX  = 6;
  localparam int LNS  = 3;
  localparam int DLY  = 2;
  localparam int LP1  = 14;
  localparam int LP2  = 11;
  localparam int LP4  = 8;
  localparam int PER  = 2 * HALF;

  typedef struct packed {
    logic [1:0] mode;
    logic       gap;
    logic [7:0] lp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{mode: 2'b00, gap: 1'b0, lp: 8'(LP1)},
    '{mode: 2'b01, gap: 1'b0, lp: 8'(LP2)},
    '{mode: 2'b10, gap: 1'b0, lp: 8'(LP4)},
    '{mode: 2'b11, gap: 1'b1, lp: 8'(LP4)},
    '{mode: 2'b00, gap: 1'b1, lp: 8'(LP1)},
    '{mode: 2'b10, gap: 1'b1, lp: 8'(LP4)}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b10;
  logic       pix_valid = 1'b1;
  logic       pix_ready;
  logic [7:0] pix_data = 8'd5;
  logic       lcd_cl2, lcd_cl1, lcd_flm, lcd_m;
  logic [3:0] lcd_du, lcd_dl;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lcd_dualscan_timing #(
    .CL2_HALF(HALF), .PIX_PER_LINE(PIX), .FRAME_LINES(LNS), .FLM_DELAY(DLY),
    .LINE_CL2_D1(LP1), .LINE_CL2_D2(LP2), .LINE_CL2_D4(LP4)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .lcd_cl2(lcd_cl2),
    .lcd_cl1(lcd_cl1), .lcd_flm(lcd_flm), .lcd_m(lcd_m),
    .lcd_du(lcd_du), .lcd_dl(lcd_dl)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: sampled on the falling edge, away from the active edge.
  int   cnt_clk = 0, cnt_cl2r = 0, cnt_cl1r = 0, cnt_flmhi = 0, cnt_flmr = 0;
  int   last_cl1 = 0, cl1_gap = 0;
  int   beats = 0;
  logic gap_en = 1'b0;
  logic [7:0] exp_beat = 8'h00;
  logic p_cl2 = 1'b0, p_cl1 = 1'b0, p_flm = 1'b0;

  always @(negedge clk) begin
    cnt_clk++;
    if (!rst) begin
      if (lcd_cl2 && !p_cl2) begin
        cnt_cl2r++;
        // R7 nibble positions, R9 blank slot on missing beat
        chk("R7/R9 data at CL2 rise", int'({lcd_du, lcd_dl}), int'(exp_beat));
      end
      if (lcd_cl1 && !p_cl1) begin
        cnt_cl1r++;
        cl1_gap  = cnt_clk - last_cl1;
        last_cl1 = cnt_clk;
        // R9 nibbles blank outside a burst
        chk("R9 data during CL1", int'({lcd_du, lcd_dl}), 0);
      end
      if (lcd_cl1 && lcd_cl2) chk("R3 CL1/CL2 overlap", 1, 0);
      if ((lcd_cl2 || lcd_cl1) && !lcd_m) chk("R10 M while running", 0, 1);
      if (lcd_flm) cnt_flmhi++;
      if (lcd_flm && !p_flm) cnt_flmr++;
      if (pix_ready) begin
        exp_beat = pix_valid ? pix_data : 8'h00;
        beats++;
      end
    end
    p_cl2 = lcd_cl2;
    p_cl1 = lcd_cl1;
    p_flm = lcd_flm;
  end

  // Source: new beat only after a ready clock, valid held otherwise.
  int beats_done = 0;
  always @(posedge clk) begin
    #1;
    if (beats != beats_done) begin
      beats_done = beats;
      pix_valid  = !(gap_en && (beats % 3 == 1));
      pix_data   = 8'(beats * 37 + 5);
    end
  end

  task automatic wait_flm(input int tgt);
    while (cnt_flmr < tgt) @(posedge clk);
  endtask

  task automatic wait_cl1(input int tgt);
    while (cnt_cl1r < tgt) @(posedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s_clk, s_cl2, s_cl1, s_flm, k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs in reset",
        int'({pix_ready, lcd_cl2, lcd_cl1, lcd_flm, lcd_m, lcd_du, lcd_dl}), 0);
    @(posedge clk); #1 rst = 1'b0;
    wait_flm(cnt_flmr + 1);

    foreach (VECS[i]) begin
      mode_sel = VECS[i].mode;
      gap_en   = VECS[i].gap;
      wait_flm(cnt_flmr + 1);
      s_clk = cnt_clk; s_cl2 = cnt_cl2r; s_cl1 = cnt_cl1r; s_flm = cnt_flmhi;
      wait_flm(cnt_flmr + 1);
      // R4 line period by mode, over a full frame
      chk("R4 frame clocks", cnt_clk - s_clk, LNS * int'(VECS[i].lp) * PER);
      // R2 pulses per frame
      chk("R2 CL2 pulses per frame", cnt_cl2r - s_cl2, LNS * PIX);
      // R3 one latch per line
      chk("R3 CL1 pulses per frame", cnt_cl1r - s_cl1, LNS);
      // R5 marker width
      chk("R5 FLM high clocks", cnt_flmhi - s_flm, (PIX + 1 - DLY) * PER);
    end

    // R6 change mid-frame: current frame keeps the 4-bit period
    mode_sel = 2'b00;
    gap_en   = 1'b0;
    wait_cl1(cnt_cl1r + 2);
    chk("R6 line period before boundary", cl1_gap, LP4 * PER);
    wait_flm(cnt_flmr + 1);
    wait_cl1(cnt_cl1r + 2);
    chk("R6 line period after boundary", cl1_gap, LP1 * PER);

    // R1 mid-run reset, then R11 restart
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset (mid-run)",
        int'({pix_ready, lcd_cl2, lcd_cl1, lcd_flm, lcd_m, lcd_du, lcd_dl}), 0);
    chk("R10 M low in reset", int'(lcd_m), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R8 prefetch ready after release", int'(pix_ready), 1);
    @(negedge clk);
    chk("R11 CL2 high on second edge", int'(lcd_cl2), 1);
    chk("R11 FLM low at slot 0", int'(lcd_flm), 0);
    chk("R10 M high once running", int'(lcd_m), 1);
    k = 0;
    while (!lcd_flm && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk("R5/R11 FLM rise slot", k, DLY * PER);
    // R6 mode sampled in reset: 1-bit period in first frame
    wait_cl1(cnt_cl1r + 2);
    chk("R6 mode sampled in reset", cl1_gap, LP1 * PER);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule